// File: doc/BRIEF.md
# Master-Mode Framed Serial Receiver

This block receives a synchronous serial stream while acting as master of both the bit clock and the frame timing. A programmable divider makes the serial clock from the system clock. Once frame generation is enabled, a sync pulse one bit period wide marks bit 0 of every frame. Each frame holds `SLOTS` slots of `WORD_W` bits. One of these slots is chosen as the receive slot. Its bits are assembled MSB first, and each complete word goes into a receive FIFO. A read request is raised while the FIFO holds at least a programmed number of words.

Software drives the block through a small register port. It programs the divider, the slot and the threshold first. It then starts the clock, and after that the frame sync and reception, which have separate enables. To shut down, it clears the receive enable and then the frame enable. This returns the frame counter to bit 0, so a later restart needs only the two enables again. A self-clearing receive reset empties the receive path. Any write to the clock configuration restarts the bit clock generator from its idle level.

Register map (word addresses on `regAddr`):
- 0: control. Bit 0 is clock enable, bit 1 is frame enable, bit 2 is receive enable. Writing 1 to bit 3 requests a receive reset; bit 3 always reads 0.
- 1: clock setup. Bits 4:0 are the prescale, bits 10:8 are the divide code.
- 2: receive setup. Bit 0 is the slot, bits 12:8 are the threshold.
- 3: data, read-only; reading it pops one word.
- 4: status. Bit 0 is the request, bit 1 is overflow, bits 12:8 are the fill level.
- All other addresses read 0.

Top module: `framedRxMaster`

## Requirements
- R1: After reset `sclkOut`, `syncOut`, `rdReq` and `regRdata` are 0, and all registers read 0.
- R2: With clock enable set, `sclkOut` toggles every (prescale+1)·2^code system clocks. Divide code 7 means a factor of 1. The output is 0 while the clock is disabled. A write to address 1 restarts it at 0.
- R3: `syncOut` appears only while the clock runs and frame enable is set. It rises together with a rising edge of `sclkOut`, stays high for one bit period, and repeats every `WORD_W`·`SLOTS` bit periods.
- R4: On each rising edge of `sclkOut`, `rxd` is sampled as the bit of the period just ending. The bits of the selected slot form a word, MSB first. The word is written to the FIFO at the edge that ends the slot's last bit.
- R5: Words are stored only when receive enable is set. A slot that is only partly captured is discarded.
- R6: Reading address 3 returns words in arrival order and pops one word. On an empty FIFO it returns 0 and pops nothing.
- R7: `rdReq` is 1 exactly while the fill level is at least the threshold. A threshold of 0 acts as 1.
- R8: A word that arrives while the FIFO holds `DEPTH` words and no pop happens is dropped. It sets the sticky overflow flag, status bit 1.
- R9: Writing 1 to control bit 3 empties the FIFO and clears overflow and any partial word. Status shows the cleared state two cycles after the write.
- R10: Clearing frame enable drops `syncOut` on the next cycle and rewinds the frame. Setting it again restarts at bit 0 with the configuration kept.
- R11: Address 1 and address 2 read back as written. Read data is registered and shows the state before the read's own effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Registered read data |
| rxd | input | 1 | Serial receive data |
| sclkOut | output | 1 | Serial bit clock output |
| syncOut | output | 1 | Frame sync output |
| rdReq | output | 1 | FIFO read request |

## Verification
A wrong divider count or a missed tick shows up directly on `sclkOut`. It also shows up on `syncOut` within one bit period, because the reference model tracks both pins every system clock. A stray frame position or slot decode shows no pin error until a word completes. It then surfaces as wrong data or a wrong request edge within one frame. A bad fill count or a stuck overflow bit shows on `rdReq` or in status at the next push or pop.

// File: rtl/framedRxPkg.sv
package framedRxPkg;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_CLKCFG = 3'd1;
  localparam logic [2:0] ADDR_RXCFG  = 3'd2;
  localparam logic [2:0] ADDR_DATA   = 3'd3;
  localparam logic [2:0] ADDR_STATUS = 3'd4;

  // strobes from control to datapath, one system clock each
  typedef struct packed {
    logic slotTick;    // bit clock rising edge inside the selected slot
    logic captureBit;  // slotTick while reception is enabled
    logic slotFirst;   // the bit ending at this tick is the slot MSB
    logic slotLast;    // the bit ending at this tick is the slot LSB
    logic popReq;      // host read of a non-empty FIFO
    logic rxClear;     // receive path reset
  } rxStrobeT;

endpackage

// File: rtl/framedRxFifo.sv
module framedRxFifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [LVL_W-1:0] level,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;

  assign full   = (level == LVL_W'(DEPTH));
  assign doPop  = pop && (level != '0);
  assign doPush = push && (!full || doPop);
  assign head   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      level <= level + 1'b1;
      else if (doPop && !doPush) level <= level - 1'b1;
    end
  end

endmodule

// File: rtl/framedRxDatapath.sv
module framedRxDatapath
  import framedRxPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobeT          strb,
  input  logic              rxd,
  input  logic [LVL_W-1:0]  threshold,
  output logic [WORD_W-1:0] fifoHead,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              overflowFlag,
  output logic              rdReq,
  output logic              pushEvent
);

  logic [WORD_W-1:0] shiftReg;
  logic              wordOk;
  logic [WORD_W-1:0] pushWord;
  logic              fifoFull;
  logic [LVL_W-1:0]  thrEff;

  // assembly: wordOk is set by the MSB and lost on any uncaptured slot bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      wordOk   <= 1'b0;
    end else if (strb.rxClear) begin
      shiftReg <= '0;
      wordOk   <= 1'b0;
    end else if (strb.slotTick) begin
      if (strb.captureBit) begin
        shiftReg <= {shiftReg[WORD_W-2:0], rxd};
        if (strb.slotLast)       wordOk <= 1'b0;
        else if (strb.slotFirst) wordOk <= 1'b1;
      end else begin
        wordOk <= 1'b0;
      end
    end
  end

  assign pushWord  = {shiftReg[WORD_W-2:0], rxd};
  assign pushEvent = strb.captureBit && strb.slotLast && wordOk && !strb.rxClear;

  framedRxFifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) fifo_i (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (strb.rxClear),
    .push     (pushEvent),
    .pushData (pushWord),
    .pop      (strb.popReq),
    .head     (fifoHead),
    .level    (fifoLevel),
    .full     (fifoFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     overflowFlag <= 1'b0;
    else if (strb.rxClear)                         overflowFlag <= 1'b0;
    else if (pushEvent && fifoFull && !strb.popReq) overflowFlag <= 1'b1;
  end

  assign thrEff = (threshold == '0) ? LVL_W'(1) : threshold;
  assign rdReq  = (fifoLevel >= thrEff);

endmodule

// File: rtl/framedRxCtrl.sv
module framedRxCtrl
  import framedRxPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SLOTS  = 2,
  parameter int DEPTH  = 16,
  parameter int PRE_W  = 5,
  parameter int DIV_W  = 3,
  localparam int LVL_W     = $clog2(DEPTH + 1),
  localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int FRAME_BITS = WORD_W * SLOTS,
  localparam int FPOS_W    = $clog2(FRAME_BITS),
  localparam int MAX_SHIFT = (1 << DIV_W) - 2,
  localparam int CNT_W     = PRE_W + 1 + MAX_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [2:0]        regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic [WORD_W-1:0] fifoHead,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic              overflowFlag,
  input  logic              rdReq,
  output logic              sclkOut,
  output logic              syncOut,
  output logic              clkEnable,
  output logic [LVL_W-1:0]  threshold,
  output rxStrobeT          strb
);

  logic              syncEnable, rxEnable, rstPulse;
  logic [PRE_W-1:0]  prescale;
  logic [DIV_W-1:0]  divCode;
  logic [SLOT_W-1:0] slotSel;
  logic              wrCtrl, wrClk, wrRx;

  assign wrCtrl = regWe && (regAddr == ADDR_CTRL);
  assign wrClk  = regWe && (regAddr == ADDR_CLKCFG);
  assign wrRx   = regWe && (regAddr == ADDR_RXCFG);

  // configuration and enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkEnable  <= 1'b0;
      syncEnable <= 1'b0;
      rxEnable   <= 1'b0;
      rstPulse   <= 1'b0;
      prescale   <= '0;
      divCode    <= '0;
      slotSel    <= '0;
      threshold  <= '0;
    end else begin
      rstPulse <= wrCtrl && regWdata[3];
      if (wrCtrl) begin
        clkEnable  <= regWdata[0];
        syncEnable <= regWdata[1];
        rxEnable   <= regWdata[2];
      end
      if (wrClk) begin
        prescale <= regWdata[PRE_W-1:0];
        divCode  <= regWdata[8 +: DIV_W];
      end
      if (wrRx) begin
        slotSel   <= regWdata[SLOT_W-1:0];
        threshold <= regWdata[8 +: LVL_W];
      end
    end
  end

  // bit clock generator: half period of (prescale+1) << code, top code bypasses
  logic [CNT_W-1:0] divCnt, halfLen;
  logic [DIV_W-1:0] shiftAmt;
  logic             sclkReg, riseTick, divRestart, halfDone;

  assign shiftAmt   = (divCode == {DIV_W{1'b1}}) ? '0 : divCode;
  assign halfLen    = (CNT_W'(prescale) + CNT_W'(1)) << shiftAmt;
  assign divRestart = !clkEnable || wrClk;
  assign halfDone   = (divCnt == halfLen - CNT_W'(1));
  assign riseTick   = !divRestart && halfDone && !sclkReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      sclkReg <= 1'b0;
    end else if (divRestart) begin
      divCnt  <= '0;
      sclkReg <= 1'b0;
    end else if (halfDone) begin
      divCnt  <= '0;
      sclkReg <= ~sclkReg;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign sclkOut = sclkReg;

  // frame position: rewinds whenever frame enable is low
  logic              frameActive;
  logic [FPOS_W-1:0] bitPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameActive <= 1'b0;
      bitPos      <= '0;
    end else if (!syncEnable) begin
      frameActive <= 1'b0;
      bitPos      <= '0;
    end else if (riseTick) begin
      if (!frameActive) begin
        frameActive <= 1'b1;
        bitPos      <= '0;
      end else if (bitPos == FPOS_W'(FRAME_BITS - 1)) begin
        bitPos <= '0;
      end else begin
        bitPos <= bitPos + 1'b1;
      end
    end
  end

  assign syncOut = frameActive && (bitPos == '0);

  // slot decode for the bit that ends at this tick
  logic inSlot;
  int   posInWord;

  assign inSlot    = ((int'(bitPos) / WORD_W) == int'(slotSel));
  assign posInWord = int'(bitPos) % WORD_W;

  always_comb begin
    strb            = '0;
    strb.slotTick   = riseTick && frameActive && syncEnable && inSlot;
    strb.captureBit = strb.slotTick && rxEnable;
    strb.slotFirst  = (posInWord == 0);
    strb.slotLast   = (posInWord == WORD_W - 1);
    strb.popReq     = regRe && (regAddr == ADDR_DATA) && (fifoLevel != '0);
    strb.rxClear    = rstPulse;
  end

  // registered read port, showing state ahead of this cycle's updates
  logic [15:0] readMux;

  always_comb begin
    readMux = '0;
    unique case (regAddr)
      ADDR_CTRL:   readMux[2:0] = {rxEnable, syncEnable, clkEnable};
      ADDR_CLKCFG: begin
        readMux[PRE_W-1:0]  = prescale;
        readMux[8 +: DIV_W] = divCode;
      end
      ADDR_RXCFG: begin
        readMux[SLOT_W-1:0] = slotSel;
        readMux[8 +: LVL_W] = threshold;
      end
      ADDR_DATA:   readMux = (fifoLevel != '0) ? 16'(fifoHead) : 16'd0;
      ADDR_STATUS: begin
        readMux[0]          = rdReq;
        readMux[1]          = overflowFlag;
        readMux[8 +: LVL_W] = fifoLevel;
      end
      default:     readMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      regRdata <= '0;
    else if (regRe) regRdata <= readMux;
  end

endmodule

// File: rtl/framedRxMaster.sv
module framedRxMaster
  import framedRxPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SLOTS  = 2,
  parameter int DEPTH  = 16,
  parameter int PRE_W  = 5,
  parameter int DIV_W  = 3,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regRe,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic        rxd,
  output logic        sclkOut,
  output logic        syncOut,
  output logic        rdReq
);

  rxStrobeT          strb;
  logic [WORD_W-1:0] fifoHead;
  logic [LVL_W-1:0]  fifoLevel;
  logic [LVL_W-1:0]  threshold;
  logic              overflowFlag, pushEvent, clkEnable;

  framedRxCtrl #(
    .WORD_W(WORD_W), .SLOTS(SLOTS), .DEPTH(DEPTH), .PRE_W(PRE_W), .DIV_W(DIV_W)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .regWe        (regWe),
    .regRe        (regRe),
    .regAddr      (regAddr),
    .regWdata     (regWdata),
    .regRdata     (regRdata),
    .fifoHead     (fifoHead),
    .fifoLevel    (fifoLevel),
    .overflowFlag (overflowFlag),
    .rdReq        (rdReq),
    .sclkOut      (sclkOut),
    .syncOut      (syncOut),
    .clkEnable    (clkEnable),
    .threshold    (threshold),
    .strb         (strb)
  );

  framedRxDatapath #(.WORD_W(WORD_W), .DEPTH(DEPTH)) data_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .rxd          (rxd),
    .threshold    (threshold),
    .fifoHead     (fifoHead),
    .fifoLevel    (fifoLevel),
    .overflowFlag (overflowFlag),
    .rdReq        (rdReq),
    .pushEvent    (pushEvent)
  );

endmodule

// File: rtl/framedRxChecker.sv
module framedRxChecker #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclkOut,
  input logic             syncOut,
  input logic             rdReq,
  input logic             clkEnable,
  input logic [LVL_W-1:0] level,
  input logic             overflow,
  input logic             rxClear,
  input logic             push,
  input logic             pop
);

  assert_clk_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !clkEnable |=> !sclkOut);

  assert_sync_on_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOut) |-> $rose(sclkOut));

  assert_no_req_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0) |-> !rdReq);

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  assert_overflow_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !rxClear && level == LVL_W'(DEPTH)) |=> overflow);

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxClear |=> (level == '0) && !overflow);

endmodule

bind framedRxMaster framedRxChecker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .sclkOut   (sclkOut),
  .syncOut   (syncOut),
  .rdReq     (rdReq),
  .clkEnable (clkEnable),
  .level     (fifoLevel),
  .overflow  (overflowFlag),
  .rxClear   (strb.rxClear),
  .push      (pushEvent),
  .pop       (strb.popReq)
);

// File: tb/framedRxMaster_tb.sv
module framedRxMaster_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        rxd = 1'b0;
  logic        sclkOut, syncOut, rdReq;

  int checks = 0;
  int failures = 0;
  string curTag = "R1";

  always #4 clk = ~clk;

  framedRxMaster dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rxd(rxd),
    .sclkOut(sclkOut), .syncOut(syncOut), .rdReq(rdReq)
  );

  // behavioural reference model, advanced once per system clock
  int mClkEn, mSyncEn, mRxEn, mPre, mDiv, mSlot, mThr, mRstP;
  int mCnt, mSclk, mAct, mPos, mFrame, mOk, mShift, mOvf, mRdata;
  int fifoQ[$];

  function automatic int patWord(int f, int s);
    return (f * 40503 + s * 4660 + 23) & 16'hFFFF;
  endfunction

  function automatic int modelRead(int a);
    int thrE;
    thrE = (mThr == 0) ? 1 : mThr;
    case (a)
      0: return (mRxEn << 2) | (mSyncEn << 1) | mClkEn;
      1: return (mDiv << 8) | mPre;
      2: return (mThr << 8) | mSlot;
      3: return (fifoQ.size() > 0) ? fifoQ[0] : 0;
      4: return (fifoQ.size() << 8) | (mOvf << 1) | ((fifoQ.size() >= thrE) ? 1 : 0);
      default: return 0;
    endcase
  endfunction

  task automatic modelReset();
    mClkEn = 0; mSyncEn = 0; mRxEn = 0; mPre = 0; mDiv = 0; mSlot = 0; mThr = 0;
    mRstP = 0; mCnt = 0; mSclk = 0; mAct = 0; mPos = 0; mFrame = 0; mOk = 0;
    mShift = 0; mOvf = 0; mRdata = 0;
    fifoQ.delete();
  endtask

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      modelReset();
      rxd = 1'b0;
    end else begin
      int half, wd, thrE, bitNow;
      bit wrC, wrK, wrR, tick, inSlot, sTick, cap, first, last, push, pop, wasFull;
      thrE = (mThr == 0) ? 1 : mThr;
      cmp("R2 sclkOut", int'(sclkOut), mSclk);
      cmp("R3 syncOut", int'(syncOut), (mAct && mPos == 0) ? 1 : 0);
      cmp("R7 rdReq", int'(rdReq), (fifoQ.size() >= thrE) ? 1 : 0);
      cmp(curTag, int'(regRdata), mRdata);
      // drive the bit for the current period, then step
      bitNow = (mAct && mSyncEn) ?
               ((patWord(mFrame, mPos / 16) >> (15 - (mPos % 16))) & 1) : 0;
      rxd = bitNow[0];
      wd = int'(regWdata);
      wrC = regWe && regAddr == 3'd0;
      wrK = regWe && regAddr == 3'd1;
      wrR = regWe && regAddr == 3'd2;
      half = (mPre + 1) << ((mDiv == 7) ? 0 : mDiv);
      tick = mClkEn && !wrK && (mCnt == half - 1) && !mSclk;
      if (regRe) mRdata = modelRead(int'(regAddr));
      inSlot = (mPos / 16) == mSlot;
      sTick = tick && mAct && mSyncEn && inSlot;
      cap = sTick && mRxEn;
      first = (mPos % 16) == 0;
      last = (mPos % 16) == 15;
      pop = regRe && regAddr == 3'd3 && fifoQ.size() > 0;
      if (mRstP) begin
        mShift = 0; mOk = 0; mOvf = 0; fifoQ.delete();
      end else begin
        push = cap && last && mOk;
        wasFull = fifoQ.size() == 16;
        if (push) wd = ((mShift << 1) | bitNow) & 16'hFFFF; else wd = 0;
        if (sTick) begin
          if (cap) begin
            mShift = ((mShift << 1) | bitNow) & 16'hFFFF;
            if (last) mOk = 0; else if (first) mOk = 1;
          end else mOk = 0;
        end
        if (pop) void'(fifoQ.pop_front());
        if (push) begin
          if (wasFull && !pop) mOvf = 1; else fifoQ.push_back(wd);
        end
      end
      if (!mClkEn || wrK) begin mCnt = 0; mSclk = 0; end
      else if (mCnt == half - 1) begin mCnt = 0; mSclk = !mSclk; end
      else mCnt++;
      if (!mSyncEn) begin mAct = 0; mPos = 0; end
      else if (tick) begin
        if (!mAct) begin mAct = 1; mPos = 0; mFrame++; end
        else if (mPos == 31) begin mPos = 0; mFrame++; end
        else mPos++;
      end
      wd = int'(regWdata);
      mRstP = (wrC && wd[3]) ? 1 : 0;
      if (wrC) begin mClkEn = wd[0]; mSyncEn = wd[1]; mRxEn = wd[2]; end
      if (wrK) begin mPre = wd & 31; mDiv = (wd >> 8) & 7; end
      if (wrR) begin mSlot = wd & 1; mThr = (wd >> 8) & 31; end
    end
  end

  task automatic regWrite(int a, int d);
    @(posedge clk); #2;
    regWe = 1'b1; regAddr = 3'(a); regWdata = 16'(d);
    @(posedge clk); #2;
    regWe = 1'b0;
  endtask

  task automatic regReadCheck(int a, int exp, string tag);
    @(posedge clk); #2;
    regRe = 1'b1; regAddr = 3'(a);
    @(posedge clk); #2;
    regRe = 1'b0;
    cmp(tag, int'(regRdata), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic scenario();
    int per, firstRise, words;
    idle(3);
    curTag = "R1 reset";
    cmp("R1 sclkOut", int'(sclkOut), 0);
    cmp("R1 syncOut", int'(syncOut), 0);
    cmp("R1 rdReq", int'(rdReq), 0);
    regReadCheck(0, 0, "R1 ctrl");
    regReadCheck(4, 0, "R1 status");

    curTag = "R11 config";
    regWrite(1, 16'h0700);            // prescale 0, code 7: half period 1
    regWrite(2, 16'h0401);            // slot 1, threshold 4
    regReadCheck(1, 16'h0700, "R11 clock setup");
    regReadCheck(2, 16'h0401, "R11 rx setup");

    curTag = "R3 clock only";
    regWrite(0, 1);
    for (int i = 0; i < 20; i++) begin
      idle(1);
      cmp("R3 no sync before frame enable", int'(syncOut), 0);
    end

    curTag = "R4 capture";
    regWrite(0, 7);
    while (int'(rdReq) == 0) idle(1);
    regReadCheck(4, (4 << 8) | 1, "R7 request at threshold");
    regReadCheck(3, patWord(1, 1), "R4 first word MSB first");
    regReadCheck(3, patWord(2, 1), "R6 second word in order");
    idle(1);
    cmp("R7 request below threshold", int'(rdReq), 0);

    curTag = "R8 fill";
    idle(64 * 20);
    regReadCheck(4, (16 << 8) | 3, "R8 overflow sticky, full");
    words = 0;
    for (int i = 0; i < 16; i++) begin
      regReadCheck(3, patWord(3 + i, 1), "R6 ordered drain");
      words++;
    end

    curTag = "R9 reset";
    regWrite(0, 16'h000F);
    idle(1);
    regReadCheck(4, 0, "R9 status cleared");
    regReadCheck(0, 7, "R9 reset bit reads 0");

    curTag = "R10 shutdown";
    regWrite(0, 3);
    regWrite(0, 1);
    for (int i = 0; i < 100; i++) begin
      idle(1);
      cmp("R10 no sync after frame disable", int'(syncOut), 0);
    end
    regReadCheck(1, 16'h0700, "R10 config kept");
    regReadCheck(3, 0, "R6 empty read gives 0");
    regReadCheck(4, 0, "R6 empty read pops nothing");

    curTag = "R5 no receive";
    regWrite(0, 3);
    idle(64 * 3);
    regReadCheck(4, 0, "R5 nothing stored without receive enable");
    regWrite(0, 7);                   // enabled mid-frame: partial slot dropped
    idle(64 * 2 + 8);
    regWrite(0, 3);
    regWrite(0, 1);

    curTag = "R2 new clock";
    regWrite(1, 16'h0101);            // prescale 1, code 1: half period 4
    regWrite(2, 16'h0000);            // slot 0, threshold 0 acts as 1
    while (int'(sclkOut) == 0) idle(1);
    firstRise = 0;
    while (int'(sclkOut) == 1) idle(1);
    per = 0;
    while (int'(sclkOut) == 0) begin idle(1); per++; end
    cmp("R2 low phase of 4", per, 4);
    regWrite(0, 7);
    while (int'(rdReq) == 0) idle(1);
    cmp("R7 threshold zero acts as one", int'(rdReq), 1 + firstRise);
    regWrite(0, 3);
    regWrite(0, 1);
    idle(300);
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    fork
      scenario();
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule